// File: doc/BRIEF.md
# Peripheral interrupt aggregation controller

This block gathers interrupt sources from four peripherals of a small power-management device and presents them to a host on a single interrupt line. Every peripheral has its own bank of 8-bit registers. Per source, the bank selects level or edge detection and holds two independent polarity bits, so a source can fire on a rising edge, a falling edge or both. The bank also keeps an enable mask and a latched pending bit. The pending bits of each bank combine into one summary bit, and the summary bits combine into the host interrupt.

Software reaches the registers over a simple synchronous bus with 16-bit addresses and 8-bit data. A write takes effect on the clock edge where it is presented. A read request is captured on its edge, and the data comes back one cycle later with a valid strobe. The source signals are synchronous inputs packed into one vector: bits 4..0 are the miscellaneous bank (undervoltage, overvoltage, two over-temperature stages and regulator overcurrent), bit 5 is the temperature alarm, bit 6 is GPIO1 and bit 7 is GPIO2.

The bus access controller is a two-state machine. In state BUS_IDLE no read data is returned. In state BUS_RESP the captured read data is presented with the strobe. The transitions are:
- READ_ACCEPT, from BUS_IDLE to BUS_RESP, on a read request.
- READ_CHAIN, from BUS_RESP to BUS_RESP, on a back-to-back read.
- RESP_DONE, from BUS_RESP to BUS_IDLE, when there is no read request.
- IDLE_HOLD, from BUS_IDLE to BUS_IDLE, when there is no read request.

Top module: `pirq_aggregator`

## Requirements
- R1: After reset, every type, polarity, enable and latched bit is 0, `irq_out` is 0 and `bus_rvalid` is 0.
- R2: A read request on one clock edge produces `bus_rvalid`=1 and the read data after that edge, for exactly one cycle per request. A cycle without a read request gives `bus_rvalid`=0. Unmapped addresses read as 0x00.
- R3: Bank pages are 0x09 (misc, bank 0), 0x24 (temperature, bank 1), 0xC0 (GPIO1, bank 2) and 0xC1 (GPIO2, bank 3). Within a page, offset 0x15 sets enables where the written bits are 1, and offset 0x16 clears enables where the written bits are 1. Written 0 bits leave enables unchanged. Reading either offset returns the enable mask.
- R4: With the type bit (offset 0x11) at 1 and only the high-polarity bit (offset 0x12) set, a 0-to-1 transition of an enabled source sets its latched bit (offset 0x18) on the next edge. A 1-to-0 transition does not.
- R5: With the type bit at 1 and only the low-polarity bit (offset 0x13) set, only a 1-to-0 transition latches.
- R6: With the type bit at 1 and both polarity bits set, both transitions latch.
- R7: With the type bit at 0, a high-polarity source latches while the input is 1, and a low-polarity source latches while the input is 0. A source that is still active sets its latched bit again on the edge after the one that cleared it.
- R8: A detected event on a disabled source does not set its latched bit.
- R9: Writing 1s to offset 0x14 clears the matching latched bits. On the clearing edge, the clear wins over a new event.
- R10: The summary register at 0x0550 has bit n set when bank n has any latched bit set. `irq_out` is 1 exactly when the summary is nonzero.
- R11: Offset 0x10 returns the live source inputs of a bank. Bits with no source (misc bits 7..5, bits 7..1 of the other banks) read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| src_in | input | 8 | Synchronous interrupt source inputs |
| irq_out | output | 1 | Host interrupt line |

## Verification
The bench goes after three timing corners:
- Clearing a level source that is still active. The bench expects a zero read immediately after the clear and a one on the following read. A design that let the new event win over the clear would never show the zero. A design that suppressed the event would never re-latch.
- Enabling a source whose level condition already holds. The bench expects the latch to appear one edge after the enable, not on the enable edge itself.
- Edge polarity. The bench toggles inputs in the wrong direction and while the source is disabled. An edge detector with swapped or merged polarity, or one that ignores the enable, would latch on those toggles.

The bench also writes all ones to the enable and type registers and checks that bits with no source stay 0.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int NUM_BANKS = 4;
    localparam int PAGE_W    = ADDR_W - 8;

    localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 16'h0550;

    localparam logic [7:0] OFF_RAW     = 8'h10;
    localparam logic [7:0] OFF_TYPE    = 8'h11;
    localparam logic [7:0] OFF_POL_HI  = 8'h12;
    localparam logic [7:0] OFF_POL_LO  = 8'h13;
    localparam logic [7:0] OFF_CLR     = 8'h14;
    localparam logic [7:0] OFF_EN_SET  = 8'h15;
    localparam logic [7:0] OFF_EN_CLR  = 8'h16;
    localparam logic [7:0] OFF_LATCHED = 8'h18;

    function automatic logic [PAGE_W-1:0] bank_page(input int idx);
        case (idx)
            0:       return 8'h09;
            1:       return 8'h24;
            2:       return 8'hC0;
            default: return 8'hC1;
        endcase
    endfunction

    function automatic int bank_width(input int idx);
        return (idx == 0) ? 5 : 1;
    endfunction

    function automatic int bank_lsb(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += bank_width(k);
        return acc;
    endfunction

    localparam int SRC_TOTAL = bank_lsb(NUM_BANKS);

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/pirq_bank.sv
module pirq_bank #(
    parameter int NSRC = 1,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      offset,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] src,
    output logic [DW-1:0]   rdata,
    output logic            pending
);
    import pirq_pkg::*;

    logic [NSRC-1:0] type_q, hi_q, lo_q, en_q, lat_q, prev_q;
    logic [NSRC-1:0] wmask, rise, fall, edge_hit, lvl_hit, hit, clr_mask, lat_d;
    logic            unused_wdata;

    assign wmask        = wdata[NSRC-1:0];
    assign unused_wdata = ^wdata;

    always_comb begin
        rise     = src & ~prev_q;
        fall     = prev_q & ~src;
        edge_hit = (hi_q & rise) | (lo_q & fall);
        lvl_hit  = (hi_q & src) | (lo_q & ~src);
        hit      = (type_q & edge_hit) | (~type_q & lvl_hit);
        clr_mask = (wr_en && offset == OFF_CLR) ? wmask : '0;
        lat_d    = (lat_q | (hit & en_q)) & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            en_q   <= '0;
            lat_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= src;
            lat_q  <= lat_d;
            if (wr_en) begin
                case (offset)
                    OFF_TYPE:   type_q <= wmask;
                    OFF_POL_HI: hi_q   <= wmask;
                    OFF_POL_LO: lo_q   <= wmask;
                    OFF_EN_SET: en_q   <= en_q | wmask;
                    OFF_EN_CLR: en_q   <= en_q & ~wmask;
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (offset)
            OFF_RAW:     rdata[NSRC-1:0] = src;
            OFF_TYPE:    rdata[NSRC-1:0] = type_q;
            OFF_POL_HI:  rdata[NSRC-1:0] = hi_q;
            OFF_POL_LO:  rdata[NSRC-1:0] = lo_q;
            OFF_EN_SET,
            OFF_EN_CLR:  rdata[NSRC-1:0] = en_q;
            OFF_LATCHED: rdata[NSRC-1:0] = lat_q;
            default:     rdata = '0;
        endcase
    end

    assign pending = |lat_q;

    // R9: a cleared bit is zero after the clearing edge
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == OFF_CLR) |=> ((lat_q & $past(wdata[NSRC-1:0])) == '0));

    // R8: a newly latched bit needs the enable of the previous cycle
    assert_latch_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((lat_q & ~$past(lat_q) & ~$past(en_q)) == '0));

    // R3: set bits are present after an enable-set write
    assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == OFF_EN_SET) |=>
            ((en_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

    // R3: cleared bits are absent after an enable-clear write
    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == OFF_EN_CLR) |=> ((en_q & $past(wdata[NSRC-1:0])) == '0));

endmodule

// File: rtl/pirq_bus_ctrl.sv
module pirq_bus_ctrl #(
    parameter int NB = 4,
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [AW-1:0]         bus_addr,
    input  logic [NB-1:0][DW-1:0] bank_rdata,
    input  logic [NB-1:0]         summary,
    output logic [NB-1:0]         bank_wr,
    output logic [7:0]            offset,
    output logic [DW-1:0]         bus_rdata,
    output logic                  bus_rvalid
);
    import pirq_pkg::*;

    bus_state_e    state_q, state_d;
    logic [NB-1:0] page_hit;
    logic [DW-1:0] rd_mux, rdata_q;
    logic          rd_req;

    assign offset = bus_addr[7:0];
    assign rd_req = bus_valid && !bus_write;

    for (genvar i = 0; i < NB; i++) begin : g_dec
        assign page_hit[i] = (bus_addr[AW-1:8] == bank_page(i));
        assign bank_wr[i]  = bus_valid && bus_write && page_hit[i];
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == SUMMARY_ADDR) rd_mux[NB-1:0] = summary;
        for (int i = 0; i < NB; i++) begin
            if (page_hit[i]) rd_mux = bank_rdata[i];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;  // READ_ACCEPT / IDLE_HOLD
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;  // READ_CHAIN / RESP_DONE
        endcase
    end

    // state register and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata_q <= rd_mux;
        end
    end

    // outputs
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
        endcase
    end

    assert_rvalid_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    assert_no_spurious_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

    assert_single_write_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr));

endmodule

// File: rtl/pirq_aggregator.sv
module pirq_aggregator #(
    parameter int ADDR_W = pirq_pkg::ADDR_W,
    parameter int DATA_W = pirq_pkg::DATA_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_valid,
    input  logic                           bus_write,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic                           bus_rvalid,
    input  logic [pirq_pkg::SRC_TOTAL-1:0] src_in,
    output logic                           irq_out
);
    import pirq_pkg::*;

    localparam int NB = NUM_BANKS;

    logic [NB-1:0]             bank_wr;
    logic [NB-1:0]             summary;
    logic [NB-1:0][DATA_W-1:0] bank_rdata;
    logic [7:0]                offset;

    pirq_bus_ctrl #(.NB(NB), .AW(ADDR_W), .DW(DATA_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bank_rdata (bank_rdata),
        .summary    (summary),
        .bank_wr    (bank_wr),
        .offset     (offset),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        localparam int W   = bank_width(i);
        localparam int LSB = bank_lsb(i);
        pirq_bank #(.NSRC(W), .DW(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr[i]),
            .offset  (offset),
            .wdata   (bus_wdata),
            .src     (src_in[LSB +: W]),
            .rdata   (bank_rdata[i]),
            .pending (summary[i])
        );
    end

    assign irq_out = |summary;

    // R10: the host line only rises when some bank has just gained a pending bit
    assert_irq_rise_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ((summary & ~$past(summary)) != '0));

endmodule

// File: tb/pirq_aggregator_tb_top.sv
module pirq_aggregator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  src_in = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    pirq_aggregator dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .src_in     (src_in),
        .irq_out    (irq_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: called just after a falling edge, returns at the next one
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_src(input logic [7:0] v);
        src_in = v;
        @(negedge clk);
    endtask

    // monitor: compares read responses against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb_q.size() == 0) begin
                check("R2 unexpected rvalid", 8'h01, 8'h00);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check($sformatf("%s @%h", it.tag, it.addr), bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
        check("R1 rvalid after reset", {7'd0, bus_rvalid}, 8'h00);
        rd(16'h0550, 8'h00, "R1 summary");
        rd(16'h0915, 8'h00, "R1 enable");
        rd(16'h0911, 8'h00, "R1 type");
        rd(16'hC113, 8'h00, "R1 pol lo");

        // R2 unmapped reads
        rd(16'h0917, 8'h00, "R2 unmapped offset");
        rd(16'h1234, 8'h00, "R2 unmapped page");
        rd(16'h0551, 8'h00, "R2 near summary");

        // R3 enable set/clear
        wr(16'h0915, 8'h05);
        rd(16'h0916, 8'h05, "R3 set read via clear reg");
        wr(16'h0915, 8'h00);
        rd(16'h0915, 8'h05, "R3 zero set no effect");
        wr(16'h0916, 8'h01);
        rd(16'h0915, 8'h04, "R3 clear bit0");
        wr(16'h0916, 8'h00);
        rd(16'h0915, 8'h04, "R3 zero clear no effect");
        // R11 bits without sources
        wr(16'h0915, 8'hFF);
        rd(16'h0915, 8'h1F, "R11 misc enable width");
        wr(16'h0916, 8'hFF);
        rd(16'h0915, 8'h00, "R3 clear all");
        wr(16'h0911, 8'hE0);
        rd(16'h0911, 8'h00, "R11 type high bits ignored");

        // R11 raw status
        set_src(8'h8A);
        rd(16'h0910, 8'h0A, "R11 misc raw");
        rd(16'hC110, 8'h01, "R11 gpio2 raw");
        rd(16'h2410, 8'h00, "R11 temp raw");
        set_src(8'h00);

        // R8 disabled source ignored
        wr(16'h2411, 8'h01);
        wr(16'h2412, 8'h01);
        set_src(8'h20);
        check("R8 irq disabled", {7'd0, irq_out}, 8'h00);
        rd(16'h2418, 8'h00, "R8 latched disabled");
        set_src(8'h00);

        // R4 rising edge on GPIO1
        wr(16'hC011, 8'h01);
        wr(16'hC012, 8'h01);
        wr(16'hC015, 8'h01);
        set_src(8'h40);
        check("R4 irq on rise", {7'd0, irq_out}, 8'h01);
        rd(16'hC018, 8'h01, "R4 latched rise");
        rd(16'h0550, 8'h04, "R10 summary gpio1");
        wr(16'hC014, 8'h01);
        rd(16'hC018, 8'h00, "R9 cleared edge");
        check("R10 irq low after clear", {7'd0, irq_out}, 8'h00);

        // R5 falling edge on GPIO2
        wr(16'hC111, 8'h01);
        wr(16'hC113, 8'h01);
        wr(16'hC115, 8'h01);
        set_src(8'hC0);
        rd(16'hC118, 8'h00, "R5 rise ignored");
        set_src(8'h40);
        rd(16'hC118, 8'h01, "R5 fall latched");
        rd(16'hC018, 8'h00, "R4 fall ignored on rising source");
        rd(16'h0550, 8'h08, "R10 summary gpio2");
        wr(16'hC114, 8'h01);

        // R6 both edges on temperature alarm
        wr(16'h2413, 8'h01);
        wr(16'h2415, 8'h01);
        set_src(8'h60);
        rd(16'h2418, 8'h01, "R6 rise latched");
        wr(16'h2414, 8'h01);
        rd(16'h2418, 8'h00, "R6 no repeat while high");
        set_src(8'h40);
        rd(16'h2418, 8'h01, "R6 fall latched");
        wr(16'h2414, 8'h01);

        // R7 level modes on misc
        wr(16'h0912, 8'h01);
        wr(16'h0915, 8'h01);
        set_src(8'h41);
        rd(16'h0918, 8'h01, "R7 level high latched");
        wr(16'h0914, 8'h01);
        rd(16'h0918, 8'h00, "R9 clear wins on clearing edge");
        rd(16'h0918, 8'h01, "R7 relatch while active");
        wr(16'h0913, 8'h04);
        wr(16'h0915, 8'h04);
        rd(16'h0918, 8'h01, "R7 no latch on enable edge");
        rd(16'h0918, 8'h05, "R7 level low latched");
        rd(16'h0915, 8'h05, "R3 enable accumulated");
        set_src(8'h45);
        wr(16'h0914, 8'h04);
        rd(16'h0918, 8'h01, "R9 clear one bit");
        set_src(8'h44);
        wr(16'h0914, 8'h01);
        rd(16'h0918, 8'h00, "R9 clear remaining");
        check("R10 irq idle", {7'd0, irq_out}, 8'h00);
        rd(16'h0550, 8'h00, "R10 summary idle");

        // R10 several banks pending together
        set_src(8'h04);
        set_src(8'h64);
        check("R10 irq multi", {7'd0, irq_out}, 8'h01);
        rd(16'h0550, 8'h06, "R10 summary multi");
        wr(16'hC014, 8'h01);
        rd(16'h0550, 8'h02, "R10 summary after one clear");
        check("R10 irq still high", {7'd0, irq_out}, 8'h01);
        wr(16'h2414, 8'h01);
        rd(16'h0550, 8'h00, "R10 summary all clear");
        check("R10 irq after all clear", {7'd0, irq_out}, 8'h00);

        repeat (3) @(negedge clk);
        check("R2 all reads answered", 8'(sb_q.size()), 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule